// File: doc/BRIEF.md
# Register Integration Reuse Table

This block sits next to the rename stage of an out-of-order core that runs speculative helper threads alongside the main instruction stream. Each time a helper instruction renames and takes a fresh physical register, the table stores the instruction address, the physical tags of its sources and the tag of its result. Each time a main-stream instruction renames, the table searches for an entry with the same address and the same current source tags. On a match the rename logic can point the instruction's destination at the helper's result register. The result is then reused with no register file access and no second execution.

The table is set associative. The set comes from the low address bits just above the instruction alignment, and replacement within a set is least recently used. An entry made by a helper branch also stores the branch outcome. When such an entry hits and the main stream predicted the other direction, the branch is resolved at rename. Any entry pushed out by an insert gives back its result tag so the register can be freed. A flush empties the whole table in one cycle and gives back every tag it held.

Top module: `reuse_table`

## Requirements
- R1: After reset the table holds no entries, every lookup misses, and all outputs are low or zero.
- R2: A lookup hits only when the address and the first source tag both equal a stored entry. When the entry uses a second source, that tag must also be equal. The hit is reported one cycle after the lookup, with `hitTag` set to the stored result tag.
- R3: Only the insert port creates entries. A lookup that misses leaves the table unchanged.
- R4: The set index is `pc[ALIGN_BITS +: log2(SETS)]`. Each set holds `WAYS` entries (4 by default), and `WAYS` different addresses can live in the same set together.
- R5: An insert fills the lowest-numbered empty way of its set. When the set is full, it replaces the least recently used way. Both a hit and an insert make a way the most recently used.
- R6: When a hit lands on a branch entry whose stored outcome differs from `lkPredTaken`, `resolveValid` is raised and `resolveTaken` carries the stored outcome. In every other case `resolveValid` stays low.
- R7: When an insert replaces a valid entry, `freeValid` is raised in the next cycle and `freeTag` carries the result tag of the entry that was removed. Filling an empty way raises nothing.
- R8: When an insert and a lookup target the same set in the same cycle, the lookup goes ahead and the insert is dropped. When they target different sets, both go ahead.
- R9: `flush` clears every entry. In the next cycle, bit `set*WAYS+way` of `flushFreeMask` is set for each entry that was valid, and field `set*WAYS+way` of `flushFreeTags` holds that entry's result tag. A lookup in the flush cycle misses.
- R10: The two-source flag must be the same in the entry and in the lookup. When that flag is low, the second source tag is not compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clear the whole table |
| insValid | input | 1 | Helper instruction renamed this cycle |
| insPc | input | PC_W | Helper instruction address |
| insSrc0 | input | TAG_W | Helper first source physical tag |
| insSrc1 | input | TAG_W | Helper second source physical tag |
| insTwoSrc | input | 1 | Helper instruction uses a second source |
| insDst | input | TAG_W | Helper result physical tag |
| insIsBranch | input | 1 | Helper instruction is a branch |
| insTaken | input | 1 | Outcome computed by the helper branch |
| lkValid | input | 1 | Main-stream instruction renamed this cycle |
| lkPc | input | PC_W | Main-stream instruction address |
| lkSrc0 | input | TAG_W | Current mapping of first source |
| lkSrc1 | input | TAG_W | Current mapping of second source |
| lkTwoSrc | input | 1 | Main-stream instruction uses a second source |
| lkPredTaken | input | 1 | Predicted direction for a main-stream branch |
| hitValid | output | 1 | Reuse hit for the previous cycle's lookup |
| hitTag | output | TAG_W | Physical tag to map the destination onto |
| resolveValid | output | 1 | Mispredicted branch resolved at rename |
| resolveTaken | output | 1 | Correct branch direction |
| freeValid | output | 1 | An insert removed a valid entry |
| freeTag | output | TAG_W | Result tag of the removed entry |
| flushFreeMask | output | SETS*WAYS | Entries that were valid when flushed |
| flushFreeTags | output | SETS*WAYS*TAG_W | Result tags of the flushed entries |

## Verification
An insert from the helper and a lookup from the main stream can arrive in the same cycle. The bench drives both at once, first with two addresses that index the same set and then with two that index different sets. The same-set case passes only if the lookup reports its hit with no `freeValid` and a later lookup of the dropped address misses. The different-set case passes only if both the hit and the new entry show up. A flush arriving together with a lookup is also driven, and the bench expects a miss together with the full free mask.

// File: rtl/rit_pkg.sv
package rit_pkg;
  typedef struct packed {
    logic doFlush;
    logic doHit;
    logic doWrite;
    logic doEvict;
  } ritStrobes_t;
endpackage

// File: rtl/rit_ctrl.sv
module rit_ctrl
  import rit_pkg::*;
#(
  parameter int unsigned SETS = 4,
  parameter int unsigned WAYS = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    flush,
  input  logic                    insValid,
  input  logic                    lkValid,
  input  logic [$clog2(SETS)-1:0] insSet,
  input  logic [$clog2(SETS)-1:0] lkSet,
  input  logic [WAYS-1:0]         matchVec,
  input  logic [WAYS-1:0]         insSetValid,
  output ritStrobes_t             strb,
  output logic [WAYS-1:0]         hitWayOH,
  output logic [WAYS-1:0]         writeWayOH
);
  localparam int unsigned WAY_W = $clog2(WAYS);

  logic [WAY_W-1:0] ageQ    [SETS][WAYS];
  logic [WAY_W-1:0] ageNext [SETS][WAYS];
  logic [WAY_W-1:0] hitIdx, victimIdx;
  logic             anyInvalid, sameSet;
  logic [WAYS-1:0]  coverMask [SETS];

  always_comb begin
    hitIdx = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (matchVec[w]) hitIdx = WAY_W'(w);
    victimIdx = '0;
    for (int w = 0; w < WAYS; w++)
      if (ageQ[insSet][w] == WAY_W'(WAYS - 1)) victimIdx = WAY_W'(w);
    anyInvalid = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!insSetValid[w]) begin
        anyInvalid = 1'b1;
        victimIdx  = WAY_W'(w);
      end
    sameSet      = insValid && lkValid && (insSet == lkSet);
    strb.doFlush = flush;
    strb.doHit   = !flush && lkValid && (|matchVec);
    strb.doWrite = !flush && insValid && !sameSet;
    strb.doEvict = strb.doWrite && !anyInvalid;
    hitWayOH     = strb.doHit   ? (WAYS'(1) << hitIdx)    : '0;
    writeWayOH   = strb.doWrite ? (WAYS'(1) << victimIdx) : '0;
  end

  // recency: age 0 is newest, WAYS-1 is the replacement candidate
  always_comb begin
    ageNext = ageQ;
    if (strb.doHit)
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == hitIdx) ageNext[lkSet][w] = '0;
        else if (ageQ[lkSet][w] < ageQ[lkSet][hitIdx])
          ageNext[lkSet][w] = ageQ[lkSet][w] + 1'b1;
      end
    if (strb.doWrite)
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == victimIdx) ageNext[insSet][w] = '0;
        else if (ageQ[insSet][w] < ageQ[insSet][victimIdx])
          ageNext[insSet][w] = ageQ[insSet][w] + 1'b1;
      end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) ageQ[s][w] <= WAY_W'(w);
    end else begin
      ageQ <= ageNext;
    end
  end

  always_comb
    for (int s = 0; s < SETS; s++) begin
      coverMask[s] = '0;
      for (int w = 0; w < WAYS; w++) coverMask[s][ageQ[s][w]] = 1'b1;
    end

  generate
    for (genvar gs = 0; gs < SETS; gs++) begin : g_ageChk
      AST_LRU_PERMUTATION: assert property (@(posedge clk) disable iff (!rstN)
        coverMask[gs] == {WAYS{1'b1}}); // R5
    end
  endgenerate

  AST_CONFLICT_DROPS_INSERT: assert property (@(posedge clk) disable iff (!rstN)
    (insValid && lkValid && insSet == lkSet) |-> (writeWayOH == '0)); // R8
endmodule

// File: rtl/rit_data.sv
module rit_data
  import rit_pkg::*;
#(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned TAG_W = 7,
  parameter int unsigned SETS  = 4,
  parameter int unsigned WAYS  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ritStrobes_t               strb,
  input  logic [WAYS-1:0]           hitWayOH,
  input  logic [WAYS-1:0]           writeWayOH,
  input  logic                      insValid,
  input  logic [$clog2(SETS)-1:0]   insSet,
  input  logic [PC_W-1:0]           insPc,
  input  logic [TAG_W-1:0]          insSrc0,
  input  logic [TAG_W-1:0]          insSrc1,
  input  logic                      insTwoSrc,
  input  logic [TAG_W-1:0]          insDst,
  input  logic                      insIsBranch,
  input  logic                      insTaken,
  input  logic                      lkValid,
  input  logic [$clog2(SETS)-1:0]   lkSet,
  input  logic [PC_W-1:0]           lkPc,
  input  logic [TAG_W-1:0]          lkSrc0,
  input  logic [TAG_W-1:0]          lkSrc1,
  input  logic                      lkTwoSrc,
  input  logic                      lkPredTaken,
  output logic [WAYS-1:0]           matchVec,
  output logic [WAYS-1:0]           insSetValid,
  output logic                      hitValid,
  output logic [TAG_W-1:0]          hitTag,
  output logic                      resolveValid,
  output logic                      resolveTaken,
  output logic                      freeValid,
  output logic [TAG_W-1:0]          freeTag,
  output logic [SETS*WAYS-1:0]      flushFreeMask,
  output logic [SETS*WAYS*TAG_W-1:0] flushFreeTags
);
  localparam int unsigned ENTRIES = SETS * WAYS;

  logic             vldQ  [SETS][WAYS];
  logic [PC_W-1:0]  pcQ   [SETS][WAYS];
  logic [TAG_W-1:0] s0Q   [SETS][WAYS];
  logic [TAG_W-1:0] s1Q   [SETS][WAYS];
  logic             twoQ  [SETS][WAYS];
  logic [TAG_W-1:0] dstQ  [SETS][WAYS];
  logic             brQ   [SETS][WAYS];
  logic             tkQ   [SETS][WAYS];

  logic [ENTRIES-1:0]       validFlat;
  logic [ENTRIES*TAG_W-1:0] dstFlat;
  logic [TAG_W-1:0]         selDst, vicDst;
  logic                     selBr, selTk, resolveNext;

  // reuse test against the indexed set
  always_comb
    for (int w = 0; w < WAYS; w++) begin
      matchVec[w] = vldQ[lkSet][w] && (pcQ[lkSet][w] == lkPc) &&
                    (s0Q[lkSet][w] == lkSrc0) && (twoQ[lkSet][w] == lkTwoSrc) &&
                    (!lkTwoSrc || (s1Q[lkSet][w] == lkSrc1));
      insSetValid[w] = vldQ[insSet][w];
    end

  always_comb begin
    selDst = '0; selBr = 1'b0; selTk = 1'b0; vicDst = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hitWayOH[w]) begin
        selDst = dstQ[lkSet][w];
        selBr  = brQ[lkSet][w];
        selTk  = tkQ[lkSet][w];
      end
      if (writeWayOH[w]) vicDst = dstQ[insSet][w];
    end
    resolveNext = strb.doHit && selBr && (selTk != lkPredTaken);
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        validFlat[s*WAYS+w] = vldQ[s][w];
        dstFlat[(s*WAYS+w)*TAG_W +: TAG_W] = vldQ[s][w] ? dstQ[s][w] : '0;
      end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) vldQ[s][w] <= 1'b0;
    end else if (strb.doFlush) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) vldQ[s][w] <= 1'b0;
    end else begin
      for (int w = 0; w < WAYS; w++)
        if (writeWayOH[w]) vldQ[insSet][w] <= 1'b1;
    end
  end

  always_ff @(posedge clk)
    for (int w = 0; w < WAYS; w++)
      if (strb.doWrite && writeWayOH[w]) begin
        pcQ[insSet][w]  <= insPc;
        s0Q[insSet][w]  <= insSrc0;
        s1Q[insSet][w]  <= insSrc1;
        twoQ[insSet][w] <= insTwoSrc;
        dstQ[insSet][w] <= insDst;
        brQ[insSet][w]  <= insIsBranch;
        tkQ[insSet][w]  <= insTaken;
      end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitValid <= 1'b0; hitTag <= '0;
      resolveValid <= 1'b0; resolveTaken <= 1'b0;
      freeValid <= 1'b0; freeTag <= '0;
      flushFreeMask <= '0; flushFreeTags <= '0;
    end else begin
      hitValid      <= strb.doHit;
      hitTag        <= strb.doHit ? selDst : '0;
      resolveValid  <= resolveNext;
      resolveTaken  <= resolveNext && selTk;
      freeValid     <= strb.doEvict;
      freeTag       <= strb.doEvict ? vicDst : '0;
      flushFreeMask <= strb.doFlush ? validFlat : '0;
      flushFreeTags <= strb.doFlush ? dstFlat : '0;
    end
  end

  AST_HIT_AFTER_LOOKUP: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> ($past(lkValid) && !$past(strb.doFlush))); // R2
  AST_RESOLVE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    resolveValid |-> hitValid); // R6
  AST_FREE_AFTER_INSERT: assert property (@(posedge clk) disable iff (!rstN)
    freeValid |-> $past(insValid)); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    strb.doFlush |=> (validFlat == '0)); // R9
endmodule

// File: rtl/reuse_table.sv
module reuse_table
  import rit_pkg::*;
#(
  parameter int unsigned PC_W       = 16,
  parameter int unsigned TAG_W      = 7,
  parameter int unsigned SETS       = 4,
  parameter int unsigned WAYS       = 4,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        flush,
  input  logic                        insValid,
  input  logic [PC_W-1:0]             insPc,
  input  logic [TAG_W-1:0]            insSrc0,
  input  logic [TAG_W-1:0]            insSrc1,
  input  logic                        insTwoSrc,
  input  logic [TAG_W-1:0]            insDst,
  input  logic                        insIsBranch,
  input  logic                        insTaken,
  input  logic                        lkValid,
  input  logic [PC_W-1:0]             lkPc,
  input  logic [TAG_W-1:0]            lkSrc0,
  input  logic [TAG_W-1:0]            lkSrc1,
  input  logic                        lkTwoSrc,
  input  logic                        lkPredTaken,
  output logic                        hitValid,
  output logic [TAG_W-1:0]            hitTag,
  output logic                        resolveValid,
  output logic                        resolveTaken,
  output logic                        freeValid,
  output logic [TAG_W-1:0]            freeTag,
  output logic [SETS*WAYS-1:0]        flushFreeMask,
  output logic [SETS*WAYS*TAG_W-1:0]  flushFreeTags
);
  localparam int unsigned IDX_W = $clog2(SETS);

  logic [IDX_W-1:0] insSet, lkSet;
  logic [WAYS-1:0]  matchVec, insSetValid, hitWayOH, writeWayOH;
  ritStrobes_t      strb;

  assign insSet = insPc[ALIGN_BITS +: IDX_W];
  assign lkSet  = lkPc[ALIGN_BITS +: IDX_W];

  rit_ctrl #(.SETS(SETS), .WAYS(WAYS)) uCtrl (
    .clk(clk), .rstN(rstN), .flush(flush), .insValid(insValid), .lkValid(lkValid),
    .insSet(insSet), .lkSet(lkSet), .matchVec(matchVec), .insSetValid(insSetValid),
    .strb(strb), .hitWayOH(hitWayOH), .writeWayOH(writeWayOH)
  );

  rit_data #(.PC_W(PC_W), .TAG_W(TAG_W), .SETS(SETS), .WAYS(WAYS)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .hitWayOH(hitWayOH), .writeWayOH(writeWayOH),
    .insValid(insValid), .insSet(insSet), .insPc(insPc), .insSrc0(insSrc0),
    .insSrc1(insSrc1), .insTwoSrc(insTwoSrc), .insDst(insDst),
    .insIsBranch(insIsBranch), .insTaken(insTaken),
    .lkValid(lkValid), .lkSet(lkSet), .lkPc(lkPc), .lkSrc0(lkSrc0), .lkSrc1(lkSrc1),
    .lkTwoSrc(lkTwoSrc), .lkPredTaken(lkPredTaken),
    .matchVec(matchVec), .insSetValid(insSetValid),
    .hitValid(hitValid), .hitTag(hitTag), .resolveValid(resolveValid),
    .resolveTaken(resolveTaken), .freeValid(freeValid), .freeTag(freeTag),
    .flushFreeMask(flushFreeMask), .flushFreeTags(flushFreeTags)
  );
endmodule

// File: tb/reuse_table_test.sv
module reuse_table_test;
  localparam int PC_W = 16, TAG_W = 7, SETS = 4, WAYS = 4;

  logic clk = 1'b0, rstN = 1'b0, flush = 1'b0;
  logic insValid = 1'b0, insTwoSrc = 1'b0, insIsBranch = 1'b0, insTaken = 1'b0;
  logic [PC_W-1:0] insPc = '0, lkPc = '0;
  logic [TAG_W-1:0] insSrc0 = '0, insSrc1 = '0, insDst = '0, lkSrc0 = '0, lkSrc1 = '0;
  logic lkValid = 1'b0, lkTwoSrc = 1'b0, lkPredTaken = 1'b0;
  logic hitValid, resolveValid, resolveTaken, freeValid;
  logic [TAG_W-1:0] hitTag, freeTag;
  logic [SETS*WAYS-1:0] flushFreeMask;
  logic [SETS*WAYS*TAG_W-1:0] flushFreeTags;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  reuse_table uut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    insValid = 1'b0; lkValid = 1'b0; flush = 1'b0;
  endtask

  task automatic setIns(int pc, int s0, int s1, bit two, int dst, bit br, bit tk);
    insValid = 1'b1; insPc = PC_W'(pc); insSrc0 = TAG_W'(s0); insSrc1 = TAG_W'(s1);
    insTwoSrc = two; insDst = TAG_W'(dst); insIsBranch = br; insTaken = tk;
  endtask

  task automatic setLk(int pc, int s0, int s1, bit two, bit pred);
    lkValid = 1'b1; lkPc = PC_W'(pc); lkSrc0 = TAG_W'(s0); lkSrc1 = TAG_W'(s1);
    lkTwoSrc = two; lkPredTaken = pred;
  endtask

  task automatic expectLk(string req, int pc, int s0, int s1, bit two, bit hit, int tag);
    setLk(pc, s0, s1, two, 1'b0); step();
    chk(req, hitValid, hit);
    if (hit) chk(req, hitTag, tag);
  endtask

  task automatic tReset();
    chk("R1 hitValid", hitValid, 0);
    chk("R1 freeValid", freeValid, 0);
    chk("R1 flushFreeMask", flushFreeMask, 0);
    expectLk("R1 miss", 'h0, 0, 0, 0, 0, 0);
    expectLk("R3 miss after miss", 'h0, 0, 0, 0, 0, 0);
  endtask

  task automatic tBasic();
    setIns('h104, 5, 6, 1, 20, 0, 0); step();
    chk("R7 no free into empty", freeValid, 0);
    expectLk("R2 exact hit", 'h104, 5, 6, 1, 1, 20);
    expectLk("R2 src1 mismatch", 'h104, 5, 7, 1, 0, 0);
    expectLk("R2 src0 mismatch", 'h104, 4, 6, 1, 0, 0);
    expectLk("R2 pc mismatch", 'h108, 5, 6, 1, 0, 0);
    expectLk("R10 two-source flag mismatch", 'h104, 5, 6, 0, 0, 0);
    setIns('h200, 3, 9, 0, 21, 0, 0); step();
    expectLk("R10 second source ignored", 'h200, 3, 55, 0, 1, 21);
  endtask

  task automatic tBranch();
    setIns('h30C, 8, 0, 0, 30, 1, 1); step();
    setLk('h30C, 8, 0, 0, 1'b0); step();
    chk("R6 hit", hitValid, 1);
    chk("R6 resolve on mispredict", resolveValid, 1);
    chk("R6 resolve outcome", resolveTaken, 1);
    setLk('h30C, 8, 0, 0, 1'b1); step();
    chk("R6 hit agree", hitValid, 1);
    chk("R6 no resolve when agreed", resolveValid, 0);
    setLk('h104, 5, 6, 1, 1'b1); step();
    chk("R6 no resolve non-branch", resolveValid, 0);
  endtask

  task automatic tLru();
    flush = 1'b1; step();
    chk("R9 flush mask", flushFreeMask, 'h1011);
    chk("R9 flush tag entry0", flushFreeTags[0*TAG_W +: TAG_W], 21);
    chk("R9 flush tag entry12", flushFreeTags[12*TAG_W +: TAG_W], 30);
    expectLk("R9 gone after flush", 'h104, 5, 6, 1, 0, 0);
    for (int i = 0; i < 4; i++) begin
      setIns('h08 + 16 * i, 1, 2, 1, 40 + i, 0, 0); step();
      chk("R7 no free while set fills", freeValid, 0);
    end
    for (int i = 0; i < 4; i++)
      expectLk("R4 four ways coexist", 'h08 + 16 * i, 1, 2, 1, 1, 40 + i);
    expectLk("R5 refresh way0", 'h08, 1, 2, 1, 1, 40);
    setIns('h48, 1, 2, 1, 44, 0, 0); step();
    chk("R7 evict flag", freeValid, 1);
    chk("R7 evict tag", freeTag, 41);
    expectLk("R5 lru victim gone", 'h18, 1, 2, 1, 0, 0);
    expectLk("R5 refreshed kept", 'h08, 1, 2, 1, 1, 40);
    expectLk("R5 new entry", 'h48, 1, 2, 1, 1, 44);
  endtask

  task automatic tConflict();
    setIns('h58, 1, 2, 1, 50, 0, 0); setLk('h08, 1, 2, 1, 1'b0); step();
    chk("R8 lookup wins", hitValid, 1);
    chk("R8 lookup tag", hitTag, 40);
    chk("R8 dropped insert frees nothing", freeValid, 0);
    expectLk("R8 dropped insert absent", 'h58, 1, 2, 1, 0, 0);
    setIns('h04, 1, 2, 1, 51, 0, 0); setLk('h08, 1, 2, 1, 1'b0); step();
    chk("R8 diff set lookup", hitValid, 1);
    expectLk("R8 diff set insert kept", 'h04, 1, 2, 1, 1, 51);
  endtask

  task automatic tFlush();
    flush = 1'b1; setLk('h08, 1, 2, 1, 1'b0); step();
    chk("R9 lookup in flush misses", hitValid, 0);
    chk("R9 flush mask full", flushFreeMask, 'h0F10);
    chk("R9 tag entry8", flushFreeTags[8*TAG_W +: TAG_W], 40);
    chk("R9 tag entry9", flushFreeTags[9*TAG_W +: TAG_W], 44);
    chk("R9 tag entry4", flushFreeTags[4*TAG_W +: TAG_W], 51);
    expectLk("R9 empty after flush", 'h08, 1, 2, 1, 0, 0);
    step();
    chk("R9 mask pulse ends", flushFreeMask, 0);
  endtask

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tReset();
    tBasic();
    tBranch();
    tLru();
    tConflict();
    tFlush();
    finish();
  end

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end
endmodule